// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Word Error Flags

This block turns an asynchronous serial line into data words. An external oversample tick paces it, with `OVS` ticks per bit. The serial input can come from the receive pin or from the local transmitter's output through an internal loop, and its polarity can be inverted. A falling edge starts a frame. The receiver checks the start bit again at mid-bit, then shifts in 5 to 8 data bits in either bit order. It then checks an optional parity bit and one or two stop bits. Each bit can be taken from a single sample or from a three-sample majority vote.

Each finished word goes into a small first-word-fall-through buffer. Five flags travel with the word: framing, parity, break, overrun and noise. The head entry is always visible at the outputs, together with an error code that picks one flag by a fixed priority. An empty indication lets a reader wait for data. A request-to-send output throttles the remote transmitter as the buffer fills.

Top module: `uart_rx_core`

## Requirements
- R1: After reset the buffer is empty (`empty_o` = 1) and `rts_o` is at its asserted level.
- R2: With `wlen_i` = 0,1,2,3 selecting 5,6,7,8 data bits, a received frame yields the data right-aligned in `rd_data_o`, with upper bits zero.
  - `msb_first_i` = 0 takes the first data bit as bit 0.
  - `msb_first_i` = 1 takes the first data bit as the top bit of the word.
  - The result is correct for any tick rate of at least one tick per `OVS` clocks.
- R3: With `par_en_i` = 1, a parity bit follows the data. `par_even_i` = 1 means data plus parity hold an even number of ones; 0 means odd. A mismatch sets the parity flag of that word.
- R4: A stop bit sampled at space sets the framing flag. `stop2_i` = 1 selects two stop bits, and either one being space counts.
- R5: A line held at space through the whole frame, stop bits included, gives one word with data 0 and both the break and framing flags set. No further word starts until the line has returned to mark.
- R6: A start bit that is at mark again at its mid-bit sample is dropped, and no word is produced.
- R7: With `majvote_i` = 1, each bit is the majority of three consecutive tick samples ending at mid-bit. The noise flag is set if the three samples of any bit disagree. With `majvote_i` = 0 the noise flag is never set.
- R8: A word that completes while the buffer is full is discarded, and the overrun flag is set on the most recently stored entry.
- R9: Words leave the buffer in arrival order. `pop_i` removes the head entry, and `pop_i` while empty has no effect.
- R10: `rts_o` is asserted while at least two buffer slots are free. It is deasserted when one or no slot is free. With `rts_en_i` = 0 it stays asserted. `rts_inv_i` = 1 makes the asserted level low instead of high.
- R11: `rx_inv_i` = 1 inverts the incoming line. `loopback_i` = 1 takes the line from `loop_tx_i` instead of `rx_i`.
- R12: `err_code_o` reports the head entry's highest-priority flag in this order: framing=1, parity=2, break=3, overrun=4, noise=5, none=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversample tick, OVS per bit |
| rx_i | input | 1 | Serial receive pin |
| loop_tx_i | input | 1 | Local transmitter line for loopback |
| loopback_i | input | 1 | Select loop_tx_i as the line |
| rx_inv_i | input | 1 | Invert the incoming line |
| majvote_i | input | 1 | Enable three-sample majority vote |
| wlen_i | input | 2 | Data bits minus 5 |
| par_en_i | input | 1 | Parity bit present |
| par_even_i | input | 1 | Even parity when 1, odd when 0 |
| stop2_i | input | 1 | Two stop bits |
| msb_first_i | input | 1 | Most significant bit received first |
| rts_en_i | input | 1 | Enable buffer-level flow control |
| rts_inv_i | input | 1 | Invert request-to-send polarity |
| pop_i | input | 1 | Remove head entry |
| rd_data_o | output | 8 | Head entry data |
| rd_frm_o | output | 1 | Head entry framing flag |
| rd_par_o | output | 1 | Head entry parity flag |
| rd_brk_o | output | 1 | Head entry break flag |
| rd_ovr_o | output | 1 | Head entry overrun flag |
| rd_nse_o | output | 1 | Head entry noise flag |
| err_code_o | output | 3 | Prioritised error code of head entry |
| empty_o | output | 1 | Buffer empty |
| rts_o | output | 1 | Request-to-send |

## Verification
The checker watches the buffer invariants on every cycle: the occupancy bound, pops on an empty buffer, and the full-buffer push that must leave the occupancy unchanged. On each cycle it also checks the request-to-send level against occupancy, the link between break and framing flags, the gating of noise by the vote enable, and the error-code priority at the head. Only the bench scenarios can show the rest:
- correct data recovery across every word length, bit order, parity and stop mode;
- the placement of a one-clock glitch relative to the vote window;
- false-start rejection and the wait for mark after a break;
- which entry receives the overrun mark.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              frm;
    logic              par;
    logic              brk;
    logic              ovr;
    logic              nse;
  } rx_word_t;

  typedef enum logic [2:0] {
    ERR_NONE = 3'd0,
    ERR_FRM  = 3'd1,
    ERR_PAR  = 3'd2,
    ERR_BRK  = 3'd3,
    ERR_OVR  = 3'd4,
    ERR_NSE  = 3'd5
  } err_code_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HOLD
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rx_i,
  input  logic loop_tx_i,
  input  logic loopback_i,
  input  logic inv_i,
  input  logic majvote_i,
  output logic line_o,
  output logic bit_o,
  output logic noise_o
);
  logic                   raw;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [1:0]             hist_q;
  logic                   maj;

  // polarity corrected before sync so reset value means mark
  assign raw = (loopback_i ? loop_tx_i : rx_i) ^ inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
  end

  assign line_o = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hist_q <= 2'b11;
    else if (tick_i) hist_q <= {hist_q[0], line_o};
  end

  assign maj     = (hist_q[1] & hist_q[0]) | (hist_q[1] & line_o) | (hist_q[0] & line_o);
  assign bit_o   = majvote_i ? maj : line_o;
  assign noise_o = majvote_i & ~((hist_q[1] == hist_q[0]) && (hist_q[0] == line_o));
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS = 8
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     line_i,
  input  logic     bit_i,
  input  logic     noise_i,
  input  logic [1:0] wlen_i,
  input  logic     par_en_i,
  input  logic     par_even_i,
  input  logic     stop2_i,
  input  logic     msb_first_i,
  output logic     push_o,
  output rx_word_t word_o
);
  localparam int unsigned CW  = $clog2(OVS);
  localparam int unsigned MID = OVS / 2;

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [2:0]        idx_q;
  logic [DATA_W-1:0] data_q;
  logic              acc_q, zero_q, nse_q, frm_q, perr_q, stop2nd_q, push_q;
  rx_word_t          word_q;

  logic       at_mid, frm_n, zero_n, nse_n;
  logic [2:0] last_idx, pos;

  assign at_mid   = (cnt_q == CW'(OVS - 1));
  assign last_idx = {1'b1, wlen_i};
  assign pos      = msb_first_i ? (last_idx - idx_q) : idx_q;
  assign frm_n    = frm_q | ~bit_i;
  assign zero_n   = zero_q & ~bit_i;
  assign nse_n    = nse_q | noise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      data_q    <= '0;
      acc_q     <= 1'b0;
      zero_q    <= 1'b1;
      nse_q     <= 1'b0;
      frm_q     <= 1'b0;
      perr_q    <= 1'b0;
      stop2nd_q <= 1'b0;
      push_q    <= 1'b0;
      word_q    <= '0;
    end else begin
      push_q <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: begin
            if (!line_i) begin
              state_q <= ST_START;
              cnt_q   <= '0;
            end
          end
          ST_START: begin
            if (cnt_q == CW'(MID - 1)) begin
              cnt_q <= '0;
              if (bit_i) begin
                state_q <= ST_IDLE;
              end else begin
                state_q   <= ST_DATA;
                idx_q     <= '0;
                data_q    <= '0;
                acc_q     <= 1'b0;
                zero_q    <= 1'b1;
                nse_q     <= noise_i;
                frm_q     <= 1'b0;
                perr_q    <= 1'b0;
                stop2nd_q <= 1'b0;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (at_mid) begin
              cnt_q       <= '0;
              data_q[pos] <= bit_i;
              acc_q       <= acc_q ^ bit_i;
              zero_q      <= zero_n;
              nse_q       <= nse_n;
              if (idx_q == last_idx) state_q <= par_en_i ? ST_PAR : ST_STOP;
              else                   idx_q   <= idx_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_PAR: begin
            if (at_mid) begin
              cnt_q   <= '0;
              perr_q  <= acc_q ^ bit_i ^ ~par_even_i;
              zero_q  <= zero_n;
              nse_q   <= nse_n;
              state_q <= ST_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (at_mid) begin
              cnt_q  <= '0;
              frm_q  <= frm_n;
              zero_q <= zero_n;
              nse_q  <= nse_n;
              if (stop2_i && !stop2nd_q) begin
                stop2nd_q <= 1'b1;
              end else begin
                push_q      <= 1'b1;
                word_q.data <= data_q;
                word_q.frm  <= frm_n;
                word_q.par  <= perr_q;
                word_q.brk  <= zero_n;
                word_q.ovr  <= 1'b0;
                word_q.nse  <= nse_n;
                // a space stop bit must clear before a new start is accepted
                state_q     <= bit_i ? ST_IDLE : ST_HOLD;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_HOLD: begin
            if (line_i) state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign push_o = push_q;
  assign word_o = word_q;
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  rx_word_t        word_i,
  input  logic            pop_i,
  output rx_word_t        head_o,
  output logic            empty_o,
  output logic [CNTW-1:0] count_o
);
  rx_word_t        mem_q [DEPTH];
  logic [AW-1:0]   wr_q, rd_q, last_wr;
  logic [CNTW-1:0] count_q;
  logic            full, do_pop, do_push, ovr_mark;

  assign full     = (count_q == CNTW'(DEPTH));
  assign empty_o  = (count_q == '0);
  assign do_pop   = pop_i & ~empty_o;
  assign do_push  = push_i & (~full | do_pop);
  assign ovr_mark = push_i & full & ~do_pop;
  assign last_wr  = (wr_q == '0) ? AW'(DEPTH - 1) : wr_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= word_i;
        wr_q        <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      end
      if (ovr_mark) mem_q[last_wr].ovr <= 1'b1;
      if (do_pop) rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      count_q <= count_q + CNTW'(do_push) - CNTW'(do_pop);
    end
  end

  assign head_o  = mem_q[rd_q];
  assign count_o = count_q;
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS         = 8,
  parameter int unsigned DEPTH       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic       loop_tx_i,
  input  logic       loopback_i,
  input  logic       rx_inv_i,
  input  logic       majvote_i,
  input  logic [1:0] wlen_i,
  input  logic       par_en_i,
  input  logic       par_even_i,
  input  logic       stop2_i,
  input  logic       msb_first_i,
  input  logic       rts_en_i,
  input  logic       rts_inv_i,
  input  logic       pop_i,
  output logic [7:0] rd_data_o,
  output logic       rd_frm_o,
  output logic       rd_par_o,
  output logic       rd_brk_o,
  output logic       rd_ovr_o,
  output logic       rd_nse_o,
  output logic [2:0] err_code_o,
  output logic       empty_o,
  output logic       rts_o
);
  localparam int unsigned CNTW = $clog2(DEPTH + 1);

  logic            line_s, bit_s, noise_s;
  logic            deser_push;
  rx_word_t        deser_word;
  rx_word_t        head;
  logic [CNTW-1:0] fifo_count;
  err_code_e       code;
  logic            rts_act;

  uart_rx_sampler #(.SYNC_STAGES(SYNC_STAGES)) sampler_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .rx_i      (rx_i),
    .loop_tx_i (loop_tx_i),
    .loopback_i(loopback_i),
    .inv_i     (rx_inv_i),
    .majvote_i (majvote_i),
    .line_o    (line_s),
    .bit_o     (bit_s),
    .noise_o   (noise_s)
  );

  uart_rx_deser #(.OVS(OVS)) deser_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .line_i     (line_s),
    .bit_i      (bit_s),
    .noise_i    (noise_s),
    .wlen_i     (wlen_i),
    .par_en_i   (par_en_i),
    .par_even_i (par_even_i),
    .stop2_i    (stop2_i),
    .msb_first_i(msb_first_i),
    .push_o     (deser_push),
    .word_o     (deser_word)
  );

  uart_rx_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (deser_push),
    .word_i (deser_word),
    .pop_i  (pop_i),
    .head_o (head),
    .empty_o(empty_o),
    .count_o(fifo_count)
  );

  always_comb begin
    if      (head.frm) code = ERR_FRM;
    else if (head.par) code = ERR_PAR;
    else if (head.brk) code = ERR_BRK;
    else if (head.ovr) code = ERR_OVR;
    else if (head.nse) code = ERR_NSE;
    else               code = ERR_NONE;
  end

  assign rts_act    = ~rts_en_i | (fifo_count <= CNTW'(DEPTH - 2));
  assign rts_o      = rts_act ^ rts_inv_i;
  assign rd_data_o  = head.data;
  assign rd_frm_o   = head.frm;
  assign rd_par_o   = head.par;
  assign rd_brk_o   = head.brk;
  assign rd_ovr_o   = head.ovr;
  assign rd_nse_o   = head.nse;
  assign err_code_o = code;
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNTW = $clog2(DEPTH + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            pop_i,
  input logic            empty_o,
  input logic            rts_o,
  input logic            rts_en_i,
  input logic            rts_inv_i,
  input logic            majvote_i,
  input logic [2:0]      err_code_o,
  input logic            rd_frm_o,
  input logic            rd_par_o,
  input logic [CNTW-1:0] count_i,
  input logic            push_i,
  input rx_word_t        word_i
);
  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CNTW'(DEPTH)); // R9

  AST_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> empty_o); // R9

  AST_OVR_DISCARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && count_i == CNTW'(DEPTH) && !pop_i) |=> (count_i == CNTW'(DEPTH))); // R8

  AST_RTS_THROTTLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rts_en_i && count_i >= CNTW'(DEPTH - 1)) |-> (rts_o == rts_inv_i)); // R10

  AST_BRK_FRM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && word_i.brk) |-> word_i.frm); // R5

  AST_NSE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !majvote_i) |-> !word_i.nse); // R7

  AST_CODE_FRM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_o && rd_frm_o) |-> (err_code_o == 3'd1)); // R12

  AST_CODE_PAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_o && !rd_frm_o && rd_par_o) |-> (err_code_o == 3'd2)); // R12
endmodule

bind uart_rx_core uart_rx_core_chk #(.DEPTH(DEPTH)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pop_i     (pop_i),
  .empty_o   (empty_o),
  .rts_o     (rts_o),
  .rts_en_i  (rts_en_i),
  .rts_inv_i (rts_inv_i),
  .majvote_i (majvote_i),
  .err_code_o(err_code_o),
  .rd_frm_o  (rd_frm_o),
  .rd_par_o  (rd_par_o),
  .count_i   (fifo_count),
  .push_i    (deser_push),
  .word_i    (deser_word)
);

// File: tb/uart_rx_core_tb_top.sv
module uart_rx_core_tb_top;
  localparam int OVS   = 8;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic rx = 1'b1, loop_tx = 1'b0;
  logic loopback = 1'b0, rx_inv = 1'b0, majvote = 1'b0;
  logic [1:0] wlen = 2'd3;
  logic par_en = 1'b0, par_even = 1'b0, stop2 = 1'b0, msb_first = 1'b0;
  logic rts_en = 1'b1, rts_inv = 1'b0, pop = 1'b0;
  logic [7:0] rd_data;
  logic rd_frm, rd_par, rd_brk, rd_ovr, rd_nse, empty, rts;
  logic [2:0] err_code;

  int n_chk = 0;
  int n_bad = 0;
  int tick_div = 1;
  int tick_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tick_cnt = (tick_cnt + 1) % tick_div;
    tick = (tick_cnt == 0);
  end

  uart_rx_core #(.OVS(OVS), .DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rx_i(rx), .loop_tx_i(loop_tx),
    .loopback_i(loopback), .rx_inv_i(rx_inv), .majvote_i(majvote), .wlen_i(wlen),
    .par_en_i(par_en), .par_even_i(par_even), .stop2_i(stop2), .msb_first_i(msb_first),
    .rts_en_i(rts_en), .rts_inv_i(rts_inv), .pop_i(pop), .rd_data_o(rd_data),
    .rd_frm_o(rd_frm), .rd_par_o(rd_par), .rd_brk_o(rd_brk), .rd_ovr_o(rd_ovr),
    .rd_nse_o(rd_nse), .err_code_o(err_code), .empty_o(empty), .rts_o(rts)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_line(input logic b);
    logic pin;
    pin = b ^ rx_inv;
    if (loopback) begin loop_tx = pin; rx = ~pin; end
    else          begin rx = pin; loop_tx = ~pin; end
  endtask

  task automatic send_frame(input logic [7:0] d, input bit flip_par, input bit flip_stop, input bit glitch);
    int nb, bp;
    logic b, p;
    logic [7:0] dm;
    nb = int'(wlen) + 5;
    bp = OVS * tick_div;
    dm = d & 8'((1 << nb) - 1);
    set_line(1'b0); hold(bp);
    for (int i = 0; i < nb; i++) begin
      b = msb_first ? dm[nb-1-i] : dm[i];
      if (glitch && i == 0) begin
        set_line(b); hold(3); set_line(~b); hold(1); set_line(b); hold(bp - 4);
      end else begin
        set_line(b); hold(bp);
      end
    end
    if (par_en) begin
      p = par_even ? ^dm : ~^dm;
      set_line(p ^ flip_par); hold(bp);
    end
    for (int s = 0; s < (stop2 ? 2 : 1); s++) begin
      set_line((flip_stop && s == (stop2 ? 1 : 0)) ? 1'b0 : 1'b1); hold(bp);
    end
    set_line(1'b1); hold(2 * bp);
  endtask

  function automatic logic [2:0] exp_code(input logic [4:0] f);
    if (f[4]) return 3'd1;
    if (f[3]) return 3'd2;
    if (f[2]) return 3'd3;
    if (f[1]) return 3'd4;
    if (f[0]) return 3'd5;
    return 3'd0;
  endfunction

  // flags packed as {frm, par, brk, ovr, nse}
  task automatic read_word(input string req, input logic [7:0] d, input logic [4:0] f);
    chk(req, "empty before read", 32'(empty), 32'd0);
    chk(req, "data", 32'(rd_data), 32'(d));
    chk(req, "flags", 32'({rd_frm, rd_par, rd_brk, rd_ovr, rd_nse}), 32'(f));
    chk("R12", "err_code", 32'(err_code), 32'(exp_code(f)));
    pop = 1'b1; @(negedge clk); pop = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d, m;
    hold(3); rst_n = 1'b1; hold(2);

    // R1 reset state
    chk("R1", "empty after reset", 32'(empty), 32'd1);
    chk("R1", "rts after reset", 32'(rts), 32'd1);

    // R2 / R3 sweep over formats, with vote on for msb-first half
    for (int wl = 0; wl < 4; wl++)
      for (int mo = 0; mo < 2; mo++)
        for (int pm = 0; pm < 3; pm++)
          for (int s = 0; s < 2; s++)
            for (int v = 0; v < 2; v++) begin
              wlen = 2'(wl); msb_first = mo[0]; majvote = mo[0];
              par_en = (pm != 0); par_even = (pm == 1); stop2 = s[0];
              d = 8'(wl * 53 + mo * 29 + pm * 17 + s * 7 + v * 101 + 3);
              m = 8'((1 << (wl + 5)) - 1);
              send_frame(d, 1'b0, 1'b0, 1'b0);
              read_word("R2", d & m, 5'b00000);
            end
    majvote = 1'b0; msb_first = 1'b0; stop2 = 1'b0;

    // R3 parity errors
    wlen = 2'd3; par_en = 1'b1; par_even = 1'b1;
    send_frame(8'h3C, 1'b1, 1'b0, 1'b0);
    read_word("R3", 8'h3C, 5'b01000);
    wlen = 2'd2; par_even = 1'b0;
    send_frame(8'h51, 1'b1, 1'b0, 1'b0);
    read_word("R3", 8'h51, 5'b01000);
    par_en = 1'b0; wlen = 2'd3;

    // R4 framing
    send_frame(8'h96, 1'b0, 1'b1, 1'b0);
    read_word("R4", 8'h96, 5'b10000);
    stop2 = 1'b1;
    send_frame(8'h69, 1'b0, 1'b1, 1'b0);
    read_word("R4", 8'h69, 5'b10000);
    stop2 = 1'b0;

    // R5 break, then no new word while line stays at space
    set_line(1'b0); hold(12 * OVS);
    read_word("R5", 8'h00, 5'b10100);
    hold(4 * OVS);
    chk("R5", "no word while line held at space", 32'(empty), 32'd1);
    set_line(1'b1); hold(2 * OVS);
    send_frame(8'hC3, 1'b0, 1'b0, 1'b0);
    read_word("R5", 8'hC3, 5'b00000);

    // R6 false start
    set_line(1'b0); hold(2); set_line(1'b1); hold(4 * OVS);
    chk("R6", "false start dropped", 32'(empty), 32'd1);
    send_frame(8'h7E, 1'b0, 1'b0, 1'b0);
    read_word("R6", 8'h7E, 5'b00000);

    // R7 majority vote and noise
    majvote = 1'b1;
    send_frame(8'hA4, 1'b0, 1'b0, 1'b1);
    read_word("R7", 8'hA4, 5'b00001);
    send_frame(8'hA5, 1'b0, 1'b0, 1'b1);
    read_word("R7", 8'hA5, 5'b00001);
    majvote = 1'b0;
    send_frame(8'hA4, 1'b0, 1'b0, 1'b1);
    read_word("R7", 8'hA4, 5'b00000);

    // R11 inversion and loopback
    rx_inv = 1'b1; set_line(1'b1); hold(2 * OVS);
    send_frame(8'h1D, 1'b0, 1'b0, 1'b0);
    read_word("R11", 8'h1D, 5'b00000);
    loopback = 1'b1; set_line(1'b1); hold(2 * OVS);
    send_frame(8'hE2, 1'b0, 1'b0, 1'b0);
    read_word("R11", 8'hE2, 5'b00000);
    rx_inv = 1'b0; set_line(1'b1); hold(2 * OVS);
    send_frame(8'h4B, 1'b0, 1'b0, 1'b0);
    read_word("R11", 8'h4B, 5'b00000);
    loopback = 1'b0; set_line(1'b1); hold(2 * OVS);

    // R8 / R9 / R10 fill, overrun, RTS levels
    for (int k = 1; k <= 5; k++) begin
      send_frame(8'(k), 1'b0, 1'b0, 1'b0);
      chk("R10", $sformatf("rts with %0d sent", k), 32'(rts), (k <= 2) ? 32'd1 : 32'd0);
    end
    rts_inv = 1'b1; hold(1);
    chk("R10", "rts inverted when full", 32'(rts), 32'd1);
    rts_en = 1'b0; hold(1);
    chk("R10", "rts disabled inverted", 32'(rts), 32'd0);
    rts_inv = 1'b0; hold(1);
    chk("R10", "rts disabled", 32'(rts), 32'd1);
    rts_en = 1'b1;
    read_word("R9", 8'd1, 5'b00000);
    read_word("R9", 8'd2, 5'b00000);
    read_word("R9", 8'd3, 5'b00000);
    read_word("R8", 8'd4, 5'b00010);
    chk("R8", "overrun word discarded", 32'(empty), 32'd1);
    pop = 1'b1; @(negedge clk); pop = 1'b0; hold(1);
    chk("R9", "pop on empty ignored", 32'(empty), 32'd1);
    send_frame(8'h5E, 1'b0, 1'b0, 1'b0);
    read_word("R9", 8'h5E, 5'b00000);
    chk("R9", "empty after single pop", 32'(empty), 32'd1);

    // R2 slower tick rate
    tick_div = 3; hold(6);
    msb_first = 1'b1; wlen = 2'd1;
    send_frame(8'h2B, 1'b0, 1'b0, 1'b0);
    read_word("R2", 8'h2B, 5'b00000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule